// File: doc/BRIEF.md
# Burst Configuration Register with Bank-Steered Readback

This unit holds the 16-bit word that sets up burst reads in a two-bank flash-style memory model. Software never addresses the word directly. It reaches the word through short command sequences written on the host bus: a write sequence that loads a new value, a read-entry sequence that turns one bank into a window onto the register, and an exit command that returns both banks to normal array reads.

The read data path is a multiplexer between the register and the data that an external array model provides. When read-entry is issued, the unit captures the bank bit of the address that comes with the command. From then on, reads that carry that bank bit return the register in the low 16 lanes and zeros in the upper lanes. Reads to the other bank still return array data.

A busy input from the program/erase engine blocks register loads but does not block reads. Chip enable only qualifies bus cycles and never disturbs the stored value.

Top module: `cfgreg_unit`

## Requirements
- R1: After reset, `cfg_word` equals the default `16'h8400`. In this value bit 15 = 1 selects asynchronous reads and bits 13:10 = 1 select the shortest latency. Reads to either bank return `array_rdata`.
- R2: A bus write is a clock edge with `ce_n` = 0 and `we_n` = 0. The write sequence is four such writes: 0xAA at offset 0x555, 0x55 at offset 0x2AA, 0xD0 at offset 0x555, then any address with the value. Offsets are the address bits below the bank bit, and only `wdata[7:0]` is compared in the first three writes. `cfg_word` takes `wdata[15:0]` from the cycle after the fourth write.
- R3: If `busy` is 1 on the fourth write of the write sequence, the value is dropped and `cfg_word` keeps its previous value.
- R4: The read-entry sequence is 0xAA at 0x555, then 0x55 at 0x2AA, then 0xC6 at 0x555. It latches address bit 11 (the bank bit) of its third write. Afterwards, reads whose bit 11 matches the latched bit return the register, and reads to the other bank return `array_rdata`.
- R5: During a register read, `rd_data[31:16]` is zero and `rd_data[15:0]` equals `cfg_word`.
- R6: Read-entry is accepted with either bank bit. Issuing it again re-latches the bank.
- R7: Register reads and read-entry work while `busy` is 1.
- R8: A write that does not match the next expected step returns the decoder to idle. It leaves the register and the read mode unchanged.
- R9: A write of 0xF0 in the low byte, issued while no data step is pending, leaves read mode. Both banks then return `array_rdata`.
- R10: With `ce_n` = 1, strobes on `we_n` are ignored and `cfg_word` does not change.
- R11: Reset restores the default value and leaves read mode, whatever the earlier state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 12 | Word address; bit 11 selects the bank |
| wdata | input | 16 | Command or register data |
| busy | input | 1 | Embedded program/erase engine active |
| array_rdata | input | 32 | Data from the array model for `addr` |
| rd_data | output | 32 | Read data after bank steering |
| cfg_word | output | 16 | Current register value for the burst logic |

## Verification
The hardest state to reach is a sequence that breaks off partway through. The stimulus aborts after a valid first unlock write and then sends the exact data cycles of a register load. A decoder that failed to return to idle would accept those cycles and change the value. Bank steering is tested by entering read mode on one bank and then on the other, with reads to both banks after each entry. Busy is tested both while a load is attempted and while a register read is made.

// File: rtl/cfgreg_pkg.sv
// Shared types and command codes for the configuration register unit.
package cfgreg_pkg;
    typedef enum logic [1:0] {
        DEC_IDLE  = 2'd0,
        DEC_UNL1  = 2'd1,
        DEC_UNL2  = 2'd2,
        DEC_WDATA = 2'd3
    } dec_state_e;

    localparam logic [7:0] CODE_UNLOCK1 = 8'hAA;
    localparam logic [7:0] CODE_UNLOCK2 = 8'h55;
    localparam logic [7:0] CODE_RDMODE  = 8'hC6;
    localparam logic [7:0] CODE_LOAD    = 8'hD0;
    localparam logic [7:0] CODE_EXIT    = 8'hF0;
endpackage

// File: rtl/cfgreg_cmd_decoder.sv
// Command sequence decoder.
// Follows the unlock steps on qualified bus writes and issues one-cycle
// pulses for read-entry, register load and exit.
// Assumes: bus_wr is already qualified by chip enable; the top address bit
// is the bank bit, and the unlock offsets ignore it.
module cfgreg_cmd_decoder
    import cfgreg_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CFG_W  = 16,
    parameter logic [ADDR_W-2:0] UNLOCK_A1 = 11'h555,
    parameter logic [ADDR_W-2:0] UNLOCK_A2 = 11'h2AA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  wdata,
    output logic              cmd_rd,
    output logic              cmd_rd_bank,
    output logic              cmd_wr,
    output logic [CFG_W-1:0]  cmd_wr_data,
    output logic              cmd_exit
);
    localparam int OFF_W = ADDR_W - 1;

    dec_state_e       state_q, state_d;
    logic [OFF_W-1:0] offset;
    logic [7:0]       code;

    assign offset      = addr[OFF_W-1:0];
    assign code        = wdata[7:0];
    assign cmd_rd_bank = addr[ADDR_W-1];
    assign cmd_wr_data = wdata;

    // Next-state and pulse decode for the current bus write.
    always_comb begin
        state_d  = state_q;
        cmd_rd   = 1'b0;
        cmd_wr   = 1'b0;
        cmd_exit = 1'b0;
        if (bus_wr) begin
            state_d = DEC_IDLE;
            unique case (state_q)
                DEC_IDLE: begin
                    if (code == CODE_EXIT)
                        cmd_exit = 1'b1;
                    else if (offset == UNLOCK_A1 && code == CODE_UNLOCK1)
                        state_d = DEC_UNL1;
                end
                DEC_UNL1: begin
                    if (code == CODE_EXIT)
                        cmd_exit = 1'b1;
                    else if (offset == UNLOCK_A2 && code == CODE_UNLOCK2)
                        state_d = DEC_UNL2;
                end
                DEC_UNL2: begin
                    if (code == CODE_EXIT)
                        cmd_exit = 1'b1;
                    else if (offset == UNLOCK_A1 && code == CODE_RDMODE)
                        cmd_rd = 1'b1;
                    else if (offset == UNLOCK_A1 && code == CODE_LOAD)
                        state_d = DEC_WDATA;
                end
                DEC_WDATA: begin
                    cmd_wr = 1'b1;
                end
                default: state_d = DEC_IDLE;
            endcase
        end
    end

    // Sequence state register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= DEC_IDLE;
        else
            state_q <= state_d;
    end
endmodule

// File: rtl/cfgreg_store.sv
// Configuration word storage.
// Loads a new value on a load pulse unless the embedded engine is busy.
// Assumes: only reset returns it to the default; chip enable has no effect.
module cfgreg_store #(
    parameter int CFG_W = 16,
    parameter logic [CFG_W-1:0] CFG_DEFAULT = 16'h8400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CFG_W-1:0] cmd_wr_data,
    input  logic             busy,
    output logic [CFG_W-1:0] cfg_word
);
    // Hold the word; take a load only when the engine is idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_word <= CFG_DEFAULT;
        else if (cmd_wr && !busy)
            cfg_word <= cmd_wr_data;
    end
endmodule

// File: rtl/cfgreg_read_mux.sv
// Read steering.
// Tracks register-read mode and the latched bank, then selects either the
// zero-padded register or the array data for each read address.
// Assumes: array_rdata already corresponds to rd_addr.
module cfgreg_read_mux #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CFG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_rd,
    input  logic              cmd_rd_bank,
    input  logic              cmd_exit,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rm_active,
    output logic              rm_bank
);
    logic [DATA_W-1:0] cfg_wide;
    logic              hit;

    // Widen the register to the bus, with the upper lanes held at zero.
    generate
        if (DATA_W > CFG_W) begin : g_pad
            assign cfg_wide = {{(DATA_W-CFG_W){1'b0}}, cfg_word};
        end else begin : g_same
            assign cfg_wide = cfg_word[DATA_W-1:0];
        end
    endgenerate

    // Mode flag and bank tag: set by read-entry, cleared by exit or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rm_active <= 1'b0;
            rm_bank   <= 1'b0;
        end else if (cmd_rd) begin
            rm_active <= 1'b1;
            rm_bank   <= cmd_rd_bank;
        end else if (cmd_exit) begin
            rm_active <= 1'b0;
        end
    end

    // Per-read selection by bank.
    assign hit     = rm_active && (rd_addr[ADDR_W-1] == rm_bank);
    assign rd_data = hit ? cfg_wide : array_rdata;
endmodule

// File: rtl/cfgreg_unit.sv
// Top: bank-aware configuration register unit.
// Qualifies bus writes with chip enable and connects the decoder, the
// storage and the read steering.
// Assumes: a single address bus serves both command writes and reads.
module cfgreg_unit #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CFG_W  = 16,
    parameter logic [CFG_W-1:0] CFG_DEFAULT = 16'h8400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  wdata,
    input  logic              busy,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [CFG_W-1:0]  cfg_word
);
    logic             bus_wr;
    logic             cmd_rd, cmd_rd_bank, cmd_wr, cmd_exit;
    logic [CFG_W-1:0] cmd_wr_data;
    logic             rm_active, rm_bank;

    assign bus_wr = !ce_n && !we_n;

    cfgreg_cmd_decoder #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .addr(addr), .wdata(wdata),
        .cmd_rd(cmd_rd), .cmd_rd_bank(cmd_rd_bank), .cmd_wr(cmd_wr),
        .cmd_wr_data(cmd_wr_data), .cmd_exit(cmd_exit)
    );

    cfgreg_store #(.CFG_W(CFG_W), .CFG_DEFAULT(CFG_DEFAULT)) u_store (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wr_data(cmd_wr_data),
        .busy(busy), .cfg_word(cfg_word)
    );

    cfgreg_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W)) u_rmux (
        .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_rd_bank(cmd_rd_bank),
        .cmd_exit(cmd_exit), .rd_addr(addr), .cfg_word(cfg_word),
        .array_rdata(array_rdata), .rd_data(rd_data),
        .rm_active(rm_active), .rm_bank(rm_bank)
    );
endmodule

// File: rtl/cfgreg_unit_chk.sv
// Assertion checker bound to the top of the configuration register unit.
module cfgreg_unit_chk #(
    parameter int CFG_W = 16,
    parameter logic [CFG_W-1:0] CFG_DEFAULT = 16'h8400
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n,
    input logic             we_n,
    input logic             busy,
    input logic [CFG_W-1:0] cfg_word,
    input logic             cmd_rd,
    input logic             cmd_rd_bank,
    input logic             cmd_wr,
    input logic             cmd_exit,
    input logic             rm_active,
    input logic             rm_bank
);
    // R2: the word changes only after an enabled, non-busy write.
    a_r2_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_word != $past(cfg_word)) |-> $past(!ce_n && !we_n && !busy));

    // R3: a busy cycle never alters the stored word.
    a_r3_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_word));

    // R10: without chip enable the word holds.
    a_r10_ce_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> $stable(cfg_word));

    // R4: read-entry sets the mode and latches the presented bank.
    a_r4_bank_latch: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd |=> (rm_active && rm_bank == $past(cmd_rd_bank)));

    // R9: exit leaves register-read mode.
    a_r9_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_exit && !cmd_rd) |=> !rm_active);

    // R8: the decoder never issues two commands at once.
    a_r8_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_rd, cmd_wr, cmd_exit}));

    // R11: reset restores the default and leaves read mode.
    a_r11_reset_state: assert property (@(posedge clk)
        !rst_n |=> (cfg_word == CFG_DEFAULT && !rm_active));
endmodule

bind cfgreg_unit cfgreg_unit_chk #(.CFG_W(CFG_W), .CFG_DEFAULT(CFG_DEFAULT)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .busy(busy),
    .cfg_word(cfg_word), .cmd_rd(cmd_rd), .cmd_rd_bank(cmd_rd_bank),
    .cmd_wr(cmd_wr), .cmd_exit(cmd_exit), .rm_active(rm_active), .rm_bank(rm_bank)
);

// File: tb/cfgreg_unit_test.sv
// Scoreboard bench for cfgreg_unit.
module cfgreg_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        busy = 1'b0;
    logic [31:0] array_rdata;
    logic [31:0] rd_data;
    logic [15:0] cfg_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit          is_cfg;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    // Array model stub: data derived from the address.
    assign array_rdata = 32'hA500_0000 | {20'h0, addr};

    cfgreg_unit uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
        .wdata(wdata), .busy(busy), .array_rdata(array_rdata),
        .rd_data(rd_data), .cfg_word(cfg_word)
    );

    function automatic logic [31:0] arr(input logic [11:0] a);
        return 32'hA500_0000 | {20'h0, a};
    endfunction

    // Monitor: pop the expected items and compare them away from the edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            act = it.is_cfg ? {16'h0, cfg_word} : rd_data;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
            end
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [15:0] d, input bit ce = 1);
        @(posedge clk); #1;
        addr = a; wdata = d; we_n = 1'b0; ce_n = ce ? 1'b0 : 1'b1;
        @(posedge clk); #1;
        we_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic load_seq(input logic [15:0] v, input bit ce = 1);
        bus_write(12'h555, 16'h00AA, ce);
        bus_write(12'h2AA, 16'h0055, ce);
        bus_write(12'h555, 16'h00D0, ce);
        bus_write(12'h000, v, ce);
    endtask

    task automatic rdmode_seq(input bit bank);
        bus_write(12'h555, 16'h00AA);
        bus_write(12'h2AA, 16'h0055);
        bus_write({bank, 11'h555}, 16'h00C6);
    endtask

    task automatic exp_cfg(input logic [15:0] v, input string req);
        @(posedge clk); #1;
        sb.push_back('{1'b1, {16'h0, v}, req});
        @(negedge clk); #1;
    endtask

    task automatic exp_read(input logic [11:0] a, input logic [31:0] v, input string req);
        @(posedge clk); #1;
        addr = a;
        sb.push_back('{1'b0, v, req});
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        exp_cfg(16'h8400, "R1 default");
        exp_read(12'h010, arr(12'h010), "R1 bank0 array");
        exp_read(12'h810, arr(12'h810), "R1 bank1 array");
        // R2: load sequence
        load_seq(16'h1234);
        exp_cfg(16'h1234, "R2 load");
        // R3: load while busy is dropped
        busy = 1'b1;
        load_seq(16'hBEEF);
        busy = 1'b0;
        exp_cfg(16'h1234, "R3 busy drop");
        // R10: strobes without chip enable are ignored
        load_seq(16'h4321, 0);
        exp_cfg(16'h1234, "R10 ce high");
        // R4 / R5: read-entry on bank 1
        rdmode_seq(1'b1);
        exp_read(12'h823, 32'h0000_1234, "R4 R5 bank1 reg");
        exp_read(12'h023, arr(12'h023), "R4 bank0 array");
        // R6: re-enter on bank 0
        rdmode_seq(1'b0);
        exp_read(12'h023, 32'h0000_1234, "R6 bank0 reg");
        exp_read(12'h823, arr(12'h823), "R6 bank1 array");
        // R7: register read while busy
        busy = 1'b1;
        exp_read(12'h001, 32'h0000_1234, "R7 read busy");
        busy = 1'b0;
        // R8: broken sequence, then load-like data cycles
        bus_write(12'h555, 16'h00AA);
        bus_write(12'h123, 16'h0055);
        bus_write(12'h555, 16'h00D0);
        bus_write(12'h000, 16'h7777);
        exp_cfg(16'h1234, "R8 abort no load");
        exp_read(12'h023, 32'h0000_1234, "R8 mode kept");
        load_seq(16'h5A5A);
        exp_read(12'h023, 32'h0000_5A5A, "R8 recover load");
        // R9: exit
        bus_write(12'h000, 16'h00F0);
        exp_read(12'h023, arr(12'h023), "R9 bank0 array");
        exp_read(12'h823, arr(12'h823), "R9 bank1 array");
        // R7: read-entry while busy
        busy = 1'b1;
        rdmode_seq(1'b1);
        busy = 1'b0;
        exp_read(12'h8AB, 32'h0000_5A5A, "R7 entry busy");
        // R11: reset from read mode with a loaded value
        load_seq(16'h0F0F);
        exp_cfg(16'h0F0F, "R11 pre");
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        exp_cfg(16'h8400, "R11 default");
        exp_read(12'h8AB, arr(12'h8AB), "R11 mode cleared");
        repeat (2) @(posedge clk);
        done = 1;
    end

    // Watchdog and summary.
    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule